// File: doc/BRIEF.md
# Translation Cache with Selective Flush

This block keeps a small, fully associative set of recent address translations. Each slot pairs a logical page tag with a physical page frame, a two-bit cache-mode code and a global flag. A lookup presents a logical page tag and gets back, within the same cycle, whether a translation is resident, together with its frame and cache mode.

New translations arrive through a fill port once a table walk outside this block has finished. The walk supplies a two-bit descriptor type, and only resident types create an entry. If a fill targets a tag that is already resident, it replaces that slot. Otherwise it takes the slot named by a round-robin pointer.

A flush command removes entries. It selects either every slot or only the slot whose tag matches a given page. It can also carry a qualifier that spares every slot whose global flag is set. The global flag plays no part in lookups. A flush and a fill in the same cycle are ordered: the flush acts first, then the fill.

Top module: `xlat_cache`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) no slot is valid, so every lookup reports a miss.
- R2: Lookup is combinational. When a valid slot holds lk_tag, lk_hit is 1 and lk_frame and lk_mode carry that slot's frame and cache-mode code in the same cycle. Otherwise lk_hit is 0 and lk_frame and lk_mode are 0.
- R3: A fill with fill_dtype 2'b01 or 2'b11 (resident) stores tag, frame, mode and global flag. A lookup of that tag hits from the next cycle on.
- R4: A fill with fill_dtype 2'b00 (invalid) or 2'b10 (indirect) allocates nothing and leaves every resident translation untouched.
- R5: A resident fill whose tag is already held by a valid slot overwrites that slot. It never creates a second copy, so at most one valid slot matches any tag.
- R6: Flush kind 2'b00 (all) invalidates every slot, global or not.
- R7: Flush kind 2'b10 (all non-global) invalidates every slot whose global flag is clear and keeps every global slot.
- R8: Flush kind 2'b01 (one page) invalidates only the slot whose tag equals fl_tag, even if it is global.
- R9: Flush kind 2'b11 (one page, non-global) invalidates the slot whose tag equals fl_tag only when its global flag is clear. A global slot with that tag stays resident.
- R10: New allocations take slots in round-robin order starting from slot 0 after reset. With 16 slots, the 17th distinct allocation evicts the first. Overwrites and non-resident fills do not move the pointer.
- R11: When a flush and a fill are in the same cycle, the flush is applied first and the fill second, so the filled translation is resident afterwards even under flush-all.
- R12: The global flag has no effect on lookups: a global slot hits exactly like a non-global one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_tag | input | TAG_W | Logical page tag to translate |
| lk_hit | output | 1 | A valid slot holds lk_tag |
| lk_frame | output | FRAME_W | Physical page frame of the hit slot, 0 on miss |
| lk_mode | output | 2 | Cache-mode code of the hit slot, 0 on miss |
| fill_en | input | 1 | Walk result is presented this cycle |
| fill_dtype | input | 2 | Descriptor type: 00 invalid, 10 indirect, 01/11 resident |
| fill_tag | input | TAG_W | Logical page tag of the walk |
| fill_frame | input | FRAME_W | Physical page frame from the descriptor |
| fill_mode | input | 2 | Cache-mode code from the descriptor |
| fill_global | input | 1 | Global flag from the descriptor |
| fl_en | input | 1 | Flush command this cycle |
| fl_kind | input | 2 | Bit 0: page-only selection; bit 1: spare global slots |
| fl_tag | input | TAG_W | Page tag for page-only flushes |

## Verification
The assertions check four things on every cycle: no tag is ever held twice, a flush-all leaves nothing valid, a global-sparing flush keeps every global slot, and a non-resident fill changes no valid bit. They also check that the replacement pointer steps and wraps only when an allocation happens. Only the bench's scenarios can show that the right frame and mode come back for a given tag and that a page flush removes the right slot. The same holds for the round-robin victim order over a full wrap and for the flush-then-fill ordering in one cycle. A behavioural model running alongside the design covers long mixed streams of fills, flushes and lookups that collide on a small tag set.

// File: rtl/xlat_pkg.sv
// Package: shared encodings for the translation cache.
// Assumes: fl_kind bit 0 selects page-only matching, bit 1 spares global slots.
package xlat_pkg;

    typedef enum logic [1:0] {
        FL_ALL     = 2'b00,
        FL_PAGE    = 2'b01,
        FL_ALL_NG  = 2'b10,
        FL_PAGE_NG = 2'b11
    } flush_kind_e;

    localparam logic [1:0] DT_INVALID  = 2'b00;
    localparam logic [1:0] DT_INDIRECT = 2'b10;

    // Resident descriptor types are those with the low bit set.
    function automatic logic dtype_resident(input logic [1:0] dt);
        return (dt == 2'b01) || (dt == 2'b11);
    endfunction

endpackage

// File: rtl/xlat_tag_cmp.sv
// Module: xlat_tag_cmp
// Compares one key against every slot tag and gates the result with a valid
// vector. Assumes the caller supplies whichever valid view it needs.
module xlat_tag_cmp #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 20
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]              key,
    output logic [ENTRIES-1:0]            match
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        // Per-slot equality gated by validity.
        assign match[i] = valid[i] && (tags[i] == key);
    end

endmodule

// File: rtl/xlat_flush_sel.sv
// Module: xlat_flush_sel
// Decides which slots a flush command removes. Assumes page_hit is already
// gated by the slot valid bits.
module xlat_flush_sel #(
    parameter int ENTRIES = 16
) (
    input  logic               fl_en,
    input  logic [1:0]         fl_kind,
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] page_hit,
    input  logic [ENTRIES-1:0] glob,
    output logic [ENTRIES-1:0] kill
);

    logic page_only;
    logic spare_glob;

    assign page_only  = fl_kind[0];
    assign spare_glob = fl_kind[1];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_sel
        // A slot dies when selected by address and not protected by the global qualifier.
        assign kill[i] = fl_en && valid[i]
                       && (!page_only || page_hit[i])
                       && !(spare_glob && glob[i]);
    end

endmodule

// File: rtl/xlat_rr_ptr.sv
// Module: xlat_rr_ptr
// Round-robin victim pointer; steps by one per allocation and wraps at
// ENTRIES-1. Assumes adv is high only for a fresh allocation.
module xlat_rr_ptr #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Advance or wrap the pointer on each allocation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
    assert_ptr_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr == LAST) |=> (ptr == '0));
    assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));

endmodule

// File: rtl/xlat_cache.sv
// Module: xlat_cache
// Fully associative translation cache with combinational lookup, walk fill
// with duplicate replacement, round-robin allocation and four flush kinds.
// Assumes flush and fill in one cycle are ordered flush-then-fill.
module xlat_cache #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 20,
    parameter int FRAME_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic               lk_hit,
    output logic [FRAME_W-1:0] lk_frame,
    output logic [1:0]         lk_mode,
    input  logic               fill_en,
    input  logic [1:0]         fill_dtype,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic [1:0]         fill_mode,
    input  logic               fill_global,
    input  logic               fl_en,
    input  logic [1:0]         fl_kind,
    input  logic [TAG_W-1:0]   fl_tag
);
    import xlat_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]              valid_q;
    logic [ENTRIES-1:0]              glob_q;
    logic [ENTRIES-1:0][TAG_W-1:0]   tag_q;
    logic [ENTRIES-1:0][FRAME_W-1:0] frame_q;
    logic [ENTRIES-1:0][1:0]         mode_q;

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;
    logic [ENTRIES-1:0] fill_match;
    logic [ENTRIES-1:0] kill;
    logic [ENTRIES-1:0] valid_mid;
    logic [ENTRIES-1:0] wr_sel;
    logic [IDX_W-1:0]   ptr;
    logic               fill_do;
    logic               fill_dup;

    xlat_tag_cmp #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) i_lk_cmp (
        .valid(valid_q), .tags(tag_q), .key(lk_tag), .match(lk_match));

    xlat_tag_cmp #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) i_fl_cmp (
        .valid(valid_q), .tags(tag_q), .key(fl_tag), .match(fl_match));

    xlat_flush_sel #(.ENTRIES(ENTRIES)) i_flush (
        .fl_en(fl_en), .fl_kind(fl_kind), .valid(valid_q),
        .page_hit(fl_match), .glob(glob_q), .kill(kill));

    // The fill sees the table as it stands after this cycle's flush.
    assign valid_mid = valid_q & ~kill;

    xlat_tag_cmp #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) i_fill_cmp (
        .valid(valid_mid), .tags(tag_q), .key(fill_tag), .match(fill_match));

    assign fill_do  = fill_en && dtype_resident(fill_dtype);
    assign fill_dup = |fill_match;

    xlat_rr_ptr #(.ENTRIES(ENTRIES)) i_ptr (
        .clk(clk), .rst_n(rst_n), .adv(fill_do && !fill_dup), .ptr(ptr));

    // Target slot: the existing copy of the tag, else the round-robin victim.
    always_comb begin
        if (fill_dup)
            wr_sel = fill_match;
        else
            wr_sel = ENTRIES'(1) << ptr;
    end

    // Merge the hit slot's payload onto the lookup outputs.
    always_comb begin
        lk_hit   = |lk_match;
        lk_frame = '0;
        lk_mode  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_frame = lk_frame | frame_q[i];
                lk_mode  = lk_mode  | mode_q[i];
            end
        end
    end

    // Apply flush then fill to the slot array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            glob_q  <= '0;
            tag_q   <= '0;
            frame_q <= '0;
            mode_q  <= '0;
        end else begin
            valid_q <= valid_mid | (fill_do ? wr_sel : '0);
            for (int i = 0; i < ENTRIES; i++) begin
                if (fill_do && wr_sel[i]) begin
                    tag_q[i]   <= fill_tag;
                    frame_q[i] <= fill_frame;
                    mode_q[i]  <= fill_mode;
                    glob_q[i]  <= fill_global;
                end
            end
        end
    end

    assert_single_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    assert_flush_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && fl_kind == FL_ALL && !fill_en) |=> (valid_q == '0));
    assert_spare_global_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && fl_kind[1] && !fill_en) |=> ((valid_q & glob_q) == $past(valid_q & glob_q)));
    assert_no_alloc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !dtype_resident(fill_dtype) && !fl_en) |=> $stable(valid_q));
    assert_fill_survives_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && dtype_resident(fill_dtype)) |=> (valid_q != '0));

endmodule

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;

    localparam int N  = 16;
    localparam int TW = 20;
    localparam int FW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] lk_tag = '0;
    logic          lk_hit;
    logic [FW-1:0] lk_frame;
    logic [1:0]    lk_mode;
    logic          fill_en = 1'b0;
    logic [1:0]    fill_dtype = '0;
    logic [TW-1:0] fill_tag = '0;
    logic [FW-1:0] fill_frame = '0;
    logic [1:0]    fill_mode = '0;
    logic          fill_global = 1'b0;
    logic          fl_en = 1'b0;
    logic [1:0]    fl_kind = '0;
    logic [TW-1:0] fl_tag = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    bit          m_valid [N];
    int unsigned m_tag   [N];
    int unsigned m_frame [N];
    int unsigned m_mode  [N];
    bit          m_glob  [N];
    int          m_ptr;

    always #4 clk = ~clk;

    xlat_cache #(.ENTRIES(N), .TAG_W(TW), .FRAME_W(FW)) i_xlat_cache (
        .clk(clk), .rst_n(rst_n), .lk_tag(lk_tag), .lk_hit(lk_hit),
        .lk_frame(lk_frame), .lk_mode(lk_mode), .fill_en(fill_en),
        .fill_dtype(fill_dtype), .fill_tag(fill_tag), .fill_frame(fill_frame),
        .fill_mode(fill_mode), .fill_global(fill_global), .fl_en(fl_en),
        .fl_kind(fl_kind), .fl_tag(fl_tag));

    task automatic model_clear();
        for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        m_ptr = 0;
    endtask

    task automatic model_update();
        bit found;
        if (fl_en) begin
            for (int i = 0; i < N; i++)
                if (m_valid[i] && (!fl_kind[0] || m_tag[i] == int'(fl_tag))
                    && !(fl_kind[1] && m_glob[i]))
                    m_valid[i] = 1'b0;
        end
        if (fill_en && fill_dtype[0]) begin
            found = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (!found && m_valid[i] && m_tag[i] == int'(fill_tag)) begin
                    found = 1'b1;
                    m_frame[i] = fill_frame; m_mode[i] = fill_mode; m_glob[i] = fill_global;
                end
            end
            if (!found) begin
                m_valid[m_ptr] = 1'b1; m_tag[m_ptr] = fill_tag; m_frame[m_ptr] = fill_frame;
                m_mode[m_ptr] = fill_mode; m_glob[m_ptr] = fill_global;
                m_ptr = (m_ptr + 1) % N;
            end
        end
    endtask

    task automatic compare_model();
        bit h = 1'b0; int unsigned f = 0; int unsigned md = 0;
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_tag[i] == int'(lk_tag)) begin
                h = 1'b1; f = m_frame[i]; md = m_mode[i];
            end
        checks++;
        if (lk_hit !== h || int'(lk_frame) != f || int'(lk_mode) != md) begin
            errors++;
            $display("FAIL R2 model tag=%0h: got hit=%0b frame=%0h mode=%0d, expected hit=%0b frame=%0h mode=%0d",
                     lk_tag, lk_hit, lk_frame, lk_mode, h, f, md);
        end
    endtask

    // One clock: compare lookup against the model, clock the design, advance the model.
    task automatic step();
        #1;
        compare_model();
        @(posedge clk);
        if (rst_n) model_update(); else model_clear();
        #1;
        fill_en = 1'b0; fl_en = 1'b0;
    endtask

    task automatic fill(input int t, input int f, input int m, input bit g, input int dt);
        fill_en = 1'b1; fill_tag = TW'(t); fill_frame = FW'(f);
        fill_mode = 2'(m); fill_global = g; fill_dtype = 2'(dt);
        step();
    endtask

    task automatic flush(input int k, input int t);
        fl_en = 1'b1; fl_kind = 2'(k); fl_tag = TW'(t);
        step();
    endtask

    task automatic probe(input int t, input bit eh, input int ef, input int em, input string req);
        lk_tag = TW'(t);
        #1;
        checks++;
        if (lk_hit !== eh || (eh && (int'(lk_frame) != ef || int'(lk_mode) != em))) begin
            errors++;
            $display("FAIL %s tag=%0h: got hit=%0b frame=%0h mode=%0d, expected hit=%0b frame=%0h mode=%0d",
                     req, t, lk_hit, lk_frame, lk_mode, eh, ef, em);
        end
        step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        #2;
        do_reset();
        probe(5, 1'b0, 0, 0, "R1");
        probe(0, 1'b0, 0, 0, "R1");
        // R3 resident fills, R2 miss on other tag, R12 global hits
        fill(5, 'h100, 1, 1'b0, 1);
        probe(5, 1'b1, 'h100, 1, "R3");
        probe(6, 1'b0, 0, 0, "R2");
        fill(6, 'h200, 2, 1'b1, 3);
        probe(6, 1'b1, 'h200, 2, "R12");
        // R4 invalid and indirect fills
        fill(7, 'h300, 3, 1'b0, 0);
        probe(7, 1'b0, 0, 0, "R4");
        fill(7, 'h300, 3, 1'b0, 2);
        probe(7, 1'b0, 0, 0, "R4");
        probe(5, 1'b1, 'h100, 1, "R4");
        // R5 overwrite, then one page flush removes the only copy
        fill(5, 'h155, 3, 1'b0, 1);
        probe(5, 1'b1, 'h155, 3, "R5");
        flush(1, 5);
        probe(5, 1'b0, 0, 0, "R5");
        // R9 page non-global flush
        fill(8, 'h800, 0, 1'b0, 1);
        flush(3, 6);
        probe(6, 1'b1, 'h200, 2, "R9");
        flush(3, 8);
        probe(8, 1'b0, 0, 0, "R9");
        // R8 page flush removes global slot only
        fill(8, 'h801, 1, 1'b0, 1);
        flush(1, 6);
        probe(6, 1'b0, 0, 0, "R8");
        probe(8, 1'b1, 'h801, 1, "R8");
        // R7 all non-global, then R6 all
        fill(9, 'h900, 2, 1'b1, 1);
        flush(2, 0);
        probe(8, 1'b0, 0, 0, "R7");
        probe(9, 1'b1, 'h900, 2, "R7");
        flush(0, 0);
        probe(9, 1'b0, 0, 0, "R6");
        // R11 flush-all and fill together
        fill_en = 1'b1; fill_tag = 10; fill_frame = 'hA00; fill_mode = 1;
        fill_global = 1'b0; fill_dtype = 1;
        flush(0, 0);
        probe(10, 1'b1, 'hA00, 1, "R11");
        // R10 round-robin wrap from reset
        do_reset();
        probe(100, 1'b0, 0, 0, "R1");
        for (int k = 0; k < N; k++) fill(100 + k, 'h1000 + k, k % 4, 1'b0, 1);
        probe(100, 1'b1, 'h1000, 0, "R10");
        probe(115, 1'b1, 'h100F, 3, "R10");
        fill(116, 'h2000, 2, 1'b0, 1);
        probe(100, 1'b0, 0, 0, "R10");
        probe(101, 1'b1, 'h1001, 1, "R10");
        probe(116, 1'b1, 'h2000, 2, "R10");
        // Mixed stream against the model
        for (int k = 0; k < 3000; k++) begin
            lk_tag = TW'($urandom_range(0, 23));
            if ($urandom_range(0, 2) != 0) begin
                fill_en = 1'b1; fill_tag = TW'($urandom_range(0, 23));
                fill_frame = FW'($urandom); fill_mode = 2'($urandom);
                fill_global = 1'($urandom); fill_dtype = 2'($urandom);
            end
            if ($urandom_range(0, 7) == 0) begin
                fl_en = 1'b1; fl_kind = 2'($urandom); fl_tag = TW'($urandom_range(0, 23));
            end
            step();
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule